// File: doc/BRIEF.md
# Three-Master Bus Arbiter with Latency Timer

This block decides which of three requesters may drive a shared card-local bus: the host (master 0), function 0 (master 1) and function 1 (master 2). Each requester raises a request line and receives a grant line back. Configuration inputs supply a 2-bit priority for each master and an 8-bit latency count. The arbiter awards an idle bus to the strongest requester and later decides whether the current owner keeps the bus or must give it up.

A latency count of zero selects strict priority mode. In this mode a stronger requester takes the bus away from the owner at once, and all other requesters wait. A nonzero latency count selects timed mode. In timed mode a rival of equal or higher priority preempts the owner only after the latency timer has run down. The timer runs only while such a rival is asking. When every priority is the same, the masters take turns, each holding the bus for the latency period.

Top module: `arb3_bus_arbiter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `gnt` is all zeros. Reset makes master 2 the most recent owner.
- R2: At most one bit of `gnt` is set. A grant is given only on a clock edge where `gnt` was zero, and only to a master whose request was high at that edge. It appears in the cycle after the request is sampled.
- R3: On an idle bus the grant goes to the requester with the highest numeric priority. Priority 3 is the strongest. The priority of master i is held in `prio[2i+1:2i]`.
- R4: When requesters on an idle bus tie on priority, the search runs in circular order host (bit 0), function 0 (bit 1), function 1 (bit 2). It starts just after the most recent owner, so after reset the host wins a tie.
- R5: If the owner's request is low at a clock edge, `gnt` becomes zero after that edge.
- R6: A grant never moves directly from one master to another. At least one cycle with `gnt` all zeros lies between a grant removal and the next grant.
- R7: With `latency` zero, an owner whose request stays high loses its grant at the next edge if any other master of strictly higher priority is requesting. Requesters of equal or lower priority never take the bus from it.
- R8: With `latency` = L nonzero, a requester of lower priority never preempts the owner. When another master of equal or higher priority requests without a break, the owner's grant is removed at the (L+1)-th edge that samples that request.
- R9: An owner with no other requester keeps its grant for as long as its own request stays high, in either mode.
- R10: With all priorities equal, `latency` nonzero and every master requesting, the grant rotates host, function 0, function 1. Each holds the bus for L+1 cycles, and each hand-over includes one idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 3 | Request lines: bit 0 host, bit 1 function 0, bit 2 function 1 |
| prio | input | 6 | Priority per master, two bits each, master i at bits 2i+1:2i |
| latency | input | 8 | Latency count; zero selects strict priority mode |
| gnt | output | 3 | Grant lines, one-hot or zero, same bit order as `req` |

## Verification
The checker tests every cycle that the grant is one-hot or zero and that it never jumps straight between masters. It also checks that a new grant goes only to a master that was requesting, and that a dropped request or a stronger rival in strict mode removes the grant on the next edge. It checks, too, that an owner with no qualifying rival keeps its grant. Two behaviours depend on a sequence of events and are shown only by the bench's scenarios: the exact L+1-edge delay before a timed preemption, and the rotation order that results from the tie rule.

// File: rtl/arb3_pkg.sv
package arb3_pkg;

    localparam int unsigned ARB_MASTERS = 3;
    localparam int unsigned ARB_PRIO_W  = 2;
    localparam int unsigned ARB_LAT_W   = 8;

    typedef enum logic {
        MODE_STRICT = 1'b0,
        MODE_TIMED  = 1'b1
    } arb_mode_e;

    // Circular successor of a master index, offset steps ahead
    function automatic int unsigned ring_step(int unsigned base, int unsigned off,
                                              int unsigned n);
        int unsigned s;
        s = base + off;
        while (s >= n) s = s - n;
        return s;
    endfunction

endpackage

// File: rtl/arb3_pick.sv
module arb3_pick #(
    parameter int unsigned N  = 3,
    parameter int unsigned PW = 2,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio,
    input  logic [IW-1:0]   last,
    output logic            valid,
    output logic [IW-1:0]   idx
);
    import arb3_pkg::*;

    logic [PW-1:0] best;
    logic          any_req;

    always_comb begin
        best    = '0;
        any_req = 1'b0;
        for (int i = 0; i < int'(N); i++) begin
            if (req[i] && (!any_req || prio[i*PW +: PW] > best)) begin
                best    = prio[i*PW +: PW];
                any_req = 1'b1;
            end
        end
    end

    always_comb begin
        int unsigned j;
        valid = 1'b0;
        idx   = '0;
        for (int off = 1; off <= int'(N); off++) begin
            j = ring_step(int'(last), off, N);
            if (!valid && req[j] && prio[j*PW +: PW] == best) begin
                valid = 1'b1;
                idx   = IW'(j);
            end
        end
    end

endmodule

// File: rtl/arb3_contend.sv
module arb3_contend #(
    parameter int unsigned N  = 3,
    parameter int unsigned PW = 2,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio,
    input  logic [IW-1:0]   owner,
    output logic            higher_any,
    output logic            peer_any
);
    logic [PW-1:0] own_p;
    logic [N-1:0]  above;
    logic [N-1:0]  level;

    always_comb begin
        own_p = '0;
        for (int i = 0; i < int'(N); i++)
            if (owner == IW'(i)) own_p = prio[i*PW +: PW];
    end

    for (genvar g = 0; g < int'(N); g++) begin : g_rival
        logic other;
        assign other    = req[g] && (owner != IW'(g));
        assign above[g] = other && (prio[g*PW +: PW] >  own_p);
        assign level[g] = other && (prio[g*PW +: PW] >= own_p);
    end

    assign higher_any = |above;
    assign peer_any   = |level;

endmodule

// File: rtl/arb3_lat_timer.sv
module arb3_lat_timer #(
    parameter int unsigned LW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [LW-1:0] load_val,
    input  logic          run,
    output logic          expired
);
    logic [LW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/arb3_bus_arbiter.sv
module arb3_bus_arbiter #(
    parameter int unsigned N  = arb3_pkg::ARB_MASTERS,
    parameter int unsigned PW = arb3_pkg::ARB_PRIO_W,
    parameter int unsigned LW = arb3_pkg::ARB_LAT_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio,
    input  logic [LW-1:0]   latency,
    output logic [N-1:0]    gnt
);
    import arb3_pkg::*;

    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]  gnt_q;
    logic [IW-1:0] last_q;
    logic          pick_valid;
    logic [IW-1:0] pick_idx;
    logic          higher_any;
    logic          peer_any;
    logic          tmr_expired;
    logic          bus_held;
    logic          owner_req;
    logic          preempt;
    logic          release_bus;
    arb_mode_e     mode;

    assign bus_held = |gnt_q;
    assign mode     = (latency == '0) ? MODE_STRICT : MODE_TIMED;

    arb3_pick #(.N(N), .PW(PW)) pick_i (
        .req   (req),
        .prio  (prio),
        .last  (last_q),
        .valid (pick_valid),
        .idx   (pick_idx)
    );

    arb3_contend #(.N(N), .PW(PW)) contend_i (
        .req        (req),
        .prio       (prio),
        .owner      (last_q),
        .higher_any (higher_any),
        .peer_any   (peer_any)
    );

    arb3_lat_timer #(.LW(LW)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (!bus_held),
        .load_val (latency),
        .run      (bus_held && peer_any),
        .expired  (tmr_expired)
    );

    always_comb begin
        owner_req = 1'b0;
        for (int i = 0; i < int'(N); i++)
            if (gnt_q[i] && req[i]) owner_req = 1'b1;
    end

    always_comb begin
        unique case (mode)
            MODE_STRICT: preempt = higher_any;
            MODE_TIMED:  preempt = peer_any && tmr_expired;
            default:     preempt = 1'b0;
        endcase
    end

    assign release_bus = bus_held && (!owner_req || preempt);

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_q  <= '0;
            last_q <= IW'(N - 1);
        end else if (!bus_held) begin
            if (pick_valid) begin
                gnt_q           <= '0;
                gnt_q[pick_idx] <= 1'b1;
                last_q          <= pick_idx;
            end
        end else if (release_bus) begin
            gnt_q <= '0;
        end
    end

    assign gnt = gnt_q;

endmodule

// File: rtl/arb3_bus_arbiter_chk.sv
module arb3_bus_arbiter_chk #(
    parameter int unsigned N  = 3,
    parameter int unsigned PW = 2,
    parameter int unsigned LW = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [N-1:0]    req,
    input logic [N*PW-1:0] prio,
    input logic [LW-1:0]   latency,
    input logic [N-1:0]    gnt
);
    logic [PW-1:0] holder_p;
    logic          rival_up;
    logic          rival_eq;

    always_comb begin
        holder_p = '0;
        for (int i = 0; i < int'(N); i++)
            if (gnt[i]) holder_p = prio[i*PW +: PW];
        rival_up = 1'b0;
        rival_eq = 1'b0;
        for (int i = 0; i < int'(N); i++) begin
            if (req[i] && !gnt[i] && prio[i*PW +: PW] >  holder_p) rival_up = 1'b1;
            if (req[i] && !gnt[i] && prio[i*PW +: PW] >= holder_p) rival_eq = 1'b1;
        end
    end

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R2
    grant_to_requester_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(gnt) == '0 && gnt != '0) |-> (($past(req) & gnt) != '0));

    // R6
    no_direct_handover_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt != '0) |=> (gnt == '0 || gnt == $past(gnt)));

    // R5
    drop_release_chk: assert property (@(posedge clk) disable iff (rst)
        ((gnt & ~req) != '0) |=> (gnt == '0));

    // R7
    strict_preempt_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt != '0 && latency == '0 && rival_up) |=> (gnt == '0));

    // R9
    owner_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        ((gnt & req) != '0 && !rival_up && (latency == '0 || !rival_eq))
            |=> (gnt == $past(gnt)));

endmodule

bind arb3_bus_arbiter arb3_bus_arbiter_chk #(.N(N), .PW(PW), .LW(LW)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .prio    (prio),
    .latency (latency),
    .gnt     (gnt)
);

// File: tb/arb3_bus_arbiter_tb_top.sv
`timescale 1ns/1ps
module arb3_bus_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] req = '0;
    logic [5:0] prio = '0;
    logic [7:0] latency = '0;
    logic [2:0] gnt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    arb3_bus_arbiter dut_i (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .prio    (prio),
        .latency (latency),
        .gnt     (gnt)
    );

    // Row: {req[2:0], prio[5:0], expected gnt[2:0]}; latency 0, fresh reset
    localparam logic [11:0] VEC [0:6] = '{
        12'b111_000000_001,   // R4 tie after reset: host
        12'b110_000000_010,   // R4 tie: function 0 follows function 1
        12'b111_101101_010,   // R3 function 0 priority 3
        12'b101_010000_100,   // R3 function 1 priority 1 over host 0
        12'b000_000000_000,   // R2 no request, no grant
        12'b110_101011_010,   // R4 host idle, tie f0/f1
        12'b011_001111_001    // R4 tie host/f0: host
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [2:0] exp);
        n_chk++;
        if (gnt !== exp) begin
            n_fail++;
            $display("FAIL %s: gnt=%b expected=%b", tag, gnt, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req = '0;
        tick();
        check("R1 during reset", 3'b000);
        tick();
        rst = 1'b0;
        check("R1 after reset", 3'b000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // Table walk: idle-bus selection
        foreach (VEC[k]) begin
            do_reset();
            latency = 8'd0;
            prio    = VEC[k][8:3];
            req     = VEC[k][11:9];
            tick();
            check($sformatf("R3/R4 vector %0d", k), VEC[k][2:0]);
        end

        // R5 / R6: release on drop, idle gap, rotation
        do_reset();
        prio = 6'b000000; latency = 8'd0;
        req = 3'b011;
        tick();  check("R4 host first", 3'b001);
        req = 3'b010;
        tick();  check("R5 drop releases", 3'b000);
        tick();  check("R6 grant after gap", 3'b010);

        // R1: reset while granted
        rst = 1'b1;
        tick();  check("R1 reset clears grant", 3'b000);
        rst = 1'b0;

        // R7: strict mode
        do_reset();
        prio = 6'b01_10_01; latency = 8'd0;
        req = 3'b001;
        tick();  check("R7 host owns", 3'b001);
        req = 3'b011;
        tick();  check("R7 higher preempts", 3'b000);
        tick();  check("R7 higher granted", 3'b010);
        req = 3'b111;
        repeat (5) tick();
        check("R7 lower waits", 3'b010);
        prio = 6'b10_10_01;
        repeat (5) tick();
        check("R7 equal waits", 3'b010);

        // R8 / R9: timed mode
        do_reset();
        prio = 6'b00_01_01; latency = 8'd4;
        req = 3'b001;
        tick();  check("R9 host owns", 3'b001);
        repeat (10) tick();
        check("R9 holds without rival", 3'b001);
        req = 3'b101;
        repeat (20) tick();
        check("R8 lower never preempts", 3'b001);
        req = 3'b111;
        repeat (4) tick();
        check("R8 held through L edges", 3'b001);
        tick();  check("R8 released at edge L+1", 3'b000);
        tick();  check("R8 equal rival granted", 3'b010);

        // R10: round robin, all equal, latency 2
        do_reset();
        prio = 6'b10_10_10; latency = 8'd2;
        req = 3'b111;
        tick();  check("R10 host first", 3'b001);
        repeat (2) tick();
        check("R10 host holds", 3'b001);
        tick();  check("R10 host released", 3'b000);
        tick();  check("R10 function 0 next", 3'b010);
        repeat (2) tick();
        check("R10 function 0 holds", 3'b010);
        tick();  check("R10 function 0 released", 3'b000);
        tick();  check("R10 function 1 next", 3'b100);
        repeat (3) tick();
        check("R10 function 1 released", 3'b000);
        tick();  check("R10 wraps to host", 3'b001);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule